// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a small up counter of parameterised width, four bits by default, that can be preset from a parallel data word. It is meant to be chained with copies of itself to build wider counters without any extra gates. Each stage has a rising-edge clock and an active-low clear. It also has an active-low parallel load and two count enables. The first enable, `en_p`, is shared by all stages of a chain. The second, `en_t`, takes the ripple carry from the stage below it. The combinational `carry_out` signals that this stage is at its top value while `en_t` is high. That output drives `en_t` of the next stage.

The actions have a fixed priority: clear wins over load, and load wins over counting. The build parameter `CLR_SYNC` picks how clear acts. With `CLR_SYNC = 0` a low `clr_n` zeroes the count at once, with no clock. With `CLR_SYNC = 1` the count is zeroed only at the next rising edge.

Top module: `preset_cascade_counter`

## Requirements
- R1: The count changes only on a rising edge of `clk`, apart from the asynchronous clear of R4; a falling edge leaves `q` unchanged.
- R2: When `clr_n` is high and `load_n` is low, the next rising edge copies `din` into `q` bit for bit, with `din[0]` going to `q[0]`, the least significant bit.
- R3: While `clr_n` is low, the count is forced to zero, and `load_n`, `en_p`, `en_t` and `din` have no effect on `q`.
- R4: With `CLR_SYNC = 0`, `q` becomes zero as soon as `clr_n` goes low, with no clock edge needed. With `CLR_SYNC = 1`, `q` keeps its value until the next rising edge with `clr_n` low, and then becomes zero.
- R5: With `clr_n`, `load_n`, `en_p` and `en_t` all high, each rising edge adds one to `q`, and the all-ones value wraps to zero.
- R6: With `clr_n` and `load_n` high and either enable low, `q` holds its value across rising edges.
- R7: `carry_out` is high exactly when `en_t` is high and `q` is all ones. `en_p` has no effect on it, and it follows `en_t` combinationally, within the same cycle.
- R8: A load takes place whatever the values of `en_p` and `en_t`.
- R9: When stages are chained, each `carry_out` feeding the next stage's `en_t`, with `clk`, `en_p`, `clr_n` and `load_n` shared, the concatenated outputs act as one wide counter. The wide counter advances when `en_p` and the lowest `en_t` are high, and the top stage's carry marks the wide all-ones value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge except asynchronous clear |
| clr_n | input | 1 | Active-low clear, asynchronous or synchronous according to `CLR_SYNC` |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_p | input | 1 | Count enable shared across a chain; does not affect carry |
| en_t | input | 1 | Count enable that also gates `carry_out`; takes the carry of the stage below |
| din | input | WIDTH | Parallel preset value, bit 0 least significant |
| q | output | WIDTH | Current count, bit 0 least significant |
| carry_out | output | 1 | High when `en_t` is high and `q` is all ones |

## Verification
The count register drives `q` directly. A wrong next-state choice therefore shows on `q` one cycle after the edge where it was made. An example is a load losing to an enable, or a hold that still increments. A wrong carry shows with no delay, as soon as `en_t` or `q` reaches the top value. In a chain, that error appears as a bad upper stage one edge later. Clear faults show at once in asynchronous mode. In synchronous mode they show at the first edge after `clr_n` falls.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
   // Action chosen for the coming clock edge, listed by rising priority.
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_COUNT = 2'd1,
      ACT_LOAD  = 2'd2,
      ACT_CLEAR = 2'd3
   } pcnt_act_e;
endpackage

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
   import pcnt_pkg::*;
(
   input  logic      clr_n,
   input  logic      load_n,
   input  logic      en_p,
   input  logic      en_t,
   output pcnt_act_e act
);
   // Fixed priority: clear, then load, then count, else hold.
   always_comb begin
      if (!clr_n)
         act = ACT_CLEAR;
      else if (!load_n)
         act = ACT_LOAD;
      else if (en_p && en_t)
         act = ACT_COUNT;
      else
         act = ACT_HOLD;
   end
endmodule

// File: rtl/pcnt_next.sv
module pcnt_next
   import pcnt_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  pcnt_act_e        act,
   input  logic [WIDTH-1:0] q,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] nxt
);
   localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

   always_comb begin
      unique case (act)
         ACT_CLEAR: nxt = '0;
         ACT_LOAD:  nxt = din;
         ACT_COUNT: nxt = q + STEP;
         default:   nxt = q;
      endcase
   end
endmodule

// File: rtl/pcnt_state.sv
module pcnt_state #(
   parameter int WIDTH    = 4,
   parameter int CLR_SYNC = 0
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] q
);
   generate
      if (CLR_SYNC == 0) begin : g_async_clr
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n)
               q <= '0;
            else
               q <= nxt;
         end

         // R3/R4: with asynchronous clear the count reads zero at every edge where clear is low
         assert_async_clear_R4: assert property (@(posedge clk)
            !clr_n |-> (q == '0));
      end else begin : g_sync_clr
         // The next-state logic already selects zero while clear is low.
         always_ff @(posedge clk) begin
            q <= nxt;
         end

         // R3/R4: with synchronous clear the count is zero one edge after clear is sampled low
         assert_sync_clear_R4: assert property (@(posedge clk)
            !clr_n |=> (q == '0));
      end
   endgenerate
endmodule

// File: rtl/pcnt_carry.sv
module pcnt_carry #(
   parameter int WIDTH = 4
) (
   input  logic             en_t,
   input  logic [WIDTH-1:0] q,
   output logic             carry
);
   always_comb carry = en_t & (&q);
endmodule

// File: rtl/preset_cascade_counter.sv
module preset_cascade_counter
   import pcnt_pkg::*;
#(
   parameter int WIDTH    = 4,
   parameter int CLR_SYNC = 0
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             load_n,
   input  logic             en_p,
   input  logic             en_t,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             carry_out
);
   localparam logic [WIDTH-1:0] TOP  = '1;
   localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("preset_cascade_counter: WIDTH must be at least 1");
      end
      if (CLR_SYNC != 0 && CLR_SYNC != 1) begin : g_bad_mode
         $error("preset_cascade_counter: CLR_SYNC must be 0 or 1");
      end
   endgenerate

   pcnt_act_e        act;
   logic [WIDTH-1:0] nxt;

   pcnt_ctrl u_ctrl (
      .clr_n  (clr_n),
      .load_n (load_n),
      .en_p   (en_p),
      .en_t   (en_t),
      .act    (act)
   );

   pcnt_next #(.WIDTH(WIDTH)) u_next (
      .act (act),
      .q   (q),
      .din (din),
      .nxt (nxt)
   );

   pcnt_state #(.WIDTH(WIDTH), .CLR_SYNC(CLR_SYNC)) u_state (
      .clk   (clk),
      .clr_n (clr_n),
      .nxt   (nxt),
      .q     (q)
   );

   pcnt_carry #(.WIDTH(WIDTH)) u_carry (
      .en_t  (en_t),
      .q     (q),
      .carry (carry_out)
   );

   // R2 and R8: a load lands on the next edge whatever the enables are
   assert_load_R2: assert property (@(posedge clk) disable iff (!clr_n)
      !load_n |=> (q == $past(din)));

   // R5: counting adds one and wraps at the width
   assert_count_R5: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && en_p && en_t) |=> (q == $past(q) + STEP));

   // R6: with an enable low and no load, the count stays put
   assert_hold_R6: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && !(en_p && en_t)) |=> $stable(q));

   // R7: carry only at the top value with en_t high
   assert_carry_top_R7: assert property (@(posedge clk) disable iff (!clr_n)
      carry_out |-> (en_t && q == TOP));

   // R7: carry always present at the top value with en_t high
   assert_carry_seen_R7: assert property (@(posedge clk) disable iff (!clr_n)
      (en_t && q == TOP) |-> carry_out);
endmodule

// File: tb/tb_preset_cascade_counter.sv
`timescale 1ns/1ps
module tb_preset_cascade_counter;
   localparam int W      = 4;
   localparam int STAGES = 3;
   localparam int CW     = W * STAGES;
   localparam int NV     = 14;

   // Vector fields: [12] clr_n, [11] load_n, [10] en_p, [9] en_t,
   // [8:5] din, [4:1] expected q after the edge, [0] expected carry.
   // Vectors cover R2, R3, R5, R6, R7, R8.
   localparam logic [12:0] VEC [NV] = '{
      13'b0_1_1_1_0101_0000_0,  // clear beats everything (R3)
      13'b1_0_0_0_1001_1001_0,  // load with both enables low (R8)
      13'b1_1_1_1_0000_1010_0,  // count (R5)
      13'b1_1_1_1_0000_1011_0,
      13'b1_1_0_1_0000_1011_0,  // en_p low holds (R6)
      13'b1_1_1_0_0000_1011_0,  // en_t low holds (R6)
      13'b1_0_0_1_1110_1110_0,  // load (R2)
      13'b1_1_1_1_0000_1111_1,  // top value with carry (R7)
      13'b1_1_1_1_0000_0000_0,  // wrap (R5)
      13'b1_0_0_1_1111_1111_1,  // carry with en_p low (R7)
      13'b1_1_0_0_0000_1111_0,  // en_t low kills carry (R7)
      13'b1_1_1_0_0000_1111_0,
      13'b0_0_1_1_0111_0000_0,  // clear over load (R3)
      13'b1_0_1_1_0011_0011_0   // load with enables high (R2)
   };

   logic clk = 1'b0;
   always #4 clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // Asynchronous-clear unit
   logic         a_clr = 1'b0, a_ld = 1'b1, a_p = 1'b0, a_t = 1'b0;
   logic [W-1:0] a_din = '0;
   logic [W-1:0] a_q;
   logic         a_c;

   // Synchronous-clear unit
   logic         s_clr = 1'b0, s_ld = 1'b1, s_p = 1'b0, s_t = 1'b0;
   logic [W-1:0] s_din = '0;
   logic [W-1:0] s_q;
   logic         s_c;

   // Chain of stages
   logic          c_clr = 1'b0, c_ld = 1'b1, c_p = 1'b0, c_t0 = 1'b0;
   logic [CW-1:0] c_din = '0;
   logic [CW-1:0] c_q;
   logic          c_cy [STAGES];

   preset_cascade_counter #(.WIDTH(W), .CLR_SYNC(0)) dut (
      .clk(clk), .clr_n(a_clr), .load_n(a_ld), .en_p(a_p), .en_t(a_t),
      .din(a_din), .q(a_q), .carry_out(a_c));

   preset_cascade_counter #(.WIDTH(W), .CLR_SYNC(1)) dut_sync (
      .clk(clk), .clr_n(s_clr), .load_n(s_ld), .en_p(s_p), .en_t(s_t),
      .din(s_din), .q(s_q), .carry_out(s_c));

   for (genvar g = 0; g < STAGES; g++) begin : g_chain
      logic ent;
      if (g == 0) begin : g_first
         assign ent = c_t0;
      end else begin : g_rest
         assign ent = c_cy[g-1];
      end
      preset_cascade_counter #(.WIDTH(W), .CLR_SYNC(0)) u_stage (
         .clk(clk), .clr_n(c_clr), .load_n(c_ld), .en_p(c_p), .en_t(ent),
         .din(c_din[g*W +: W]), .q(c_q[g*W +: W]), .carry_out(c_cy[g]));
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic edge1();
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(8 * 50000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [CW-1:0] ref_cnt;

      // Reset state: asynchronous unit is zero before any clock edge (R4)
      #2;
      chk("R4 async clear at time zero", int'(a_q), 0);
      chk("R7 carry low in clear", int'(a_c), 0);
      edge1();
      edge1();
      chk("R4 sync clear after edge", int'(s_q), 0);
      chk("R3 chain cleared", int'(c_q), 0);
      a_clr = 1'b1; s_clr = 1'b1; c_clr = 1'b1;

      // Table walk on the asynchronous unit
      for (int i = 0; i < NV; i++) begin
         logic [12:0] v;
         v = VEC[i];
         a_clr = v[12]; a_ld = v[11]; a_p = v[10]; a_t = v[9]; a_din = v[8:5];
         edge1();
         n_chk++;
         if (a_q !== v[4:1] || a_c !== v[0]) begin
            n_fail++;
            $display("FAIL table vec %0d (R2,R3,R5,R6,R7,R8): got q=%0d c=%0d expected q=%0d c=%0d",
                     i, a_q, a_c, v[4:1], v[0]);
         end
      end

      // R1: falling edge does not move the count
      a_ld = 1'b0; a_din = 4'd3; a_p = 1'b1; a_t = 1'b1;
      edge1();
      a_ld = 1'b1;
      edge1();
      chk("R1 count after rising edge", int'(a_q), 4);
      #4;
      chk("R1 no change at falling edge", int'(a_q), 4);

      // R7: carry follows en_t between edges
      a_ld = 1'b0; a_din = 4'd15; a_t = 1'b0; a_p = 1'b0;
      edge1();
      a_ld = 1'b1;
      chk("R7 no carry with en_t low", int'(a_c), 0);
      #2 a_t = 1'b1;
      #1 chk("R7 carry rises with en_t, no edge", int'(a_c), 1);
      a_t = 1'b0;
      #1 chk("R7 carry falls with en_t, no edge", int'(a_c), 0);

      // R4: asynchronous clear acts mid-cycle
      a_ld = 1'b0; a_din = 4'd12;
      edge1();
      a_ld = 1'b1; a_p = 1'b0; a_t = 1'b0;
      chk("R2 load 12", int'(a_q), 12);
      #2 a_clr = 1'b0;
      #1 chk("R4 async clear without clock", int'(a_q), 0);
      edge1();
      a_clr = 1'b1;
      edge1();
      chk("R6 stays zero after clear release", int'(a_q), 0);

      // R4: synchronous clear waits for the edge
      s_ld = 1'b0; s_din = 4'd6;
      edge1();
      s_ld = 1'b1;
      chk("R2 sync unit load 6", int'(s_q), 6);
      #2 s_clr = 1'b0; s_p = 1'b1; s_t = 1'b1; s_ld = 1'b0; s_din = 4'd9;
      #1 chk("R4 sync clear no early effect", int'(s_q), 6);
      edge1();
      chk("R3 sync clear beats load and count", int'(s_q), 0);
      s_clr = 1'b1; s_ld = 1'b1;
      edge1();
      chk("R5 sync unit counts after clear", int'(s_q), 1);

      // R9: chain against a wide reference counter
      c_ld = 1'b0; c_din = 12'hFF0; c_t0 = 1'b1; c_p = 1'b0;
      edge1();
      ref_cnt = 12'hFF0;
      chk("R9 chain load", int'(c_q), int'(ref_cnt));
      c_ld = 1'b1;
      for (int i = 0; i < 60; i++) begin
         c_p  = (i % 5) != 3;
         c_t0 = i < 50;
         #1 chk("R9 chain top carry", int'(c_cy[STAGES-1]),
                int'(c_t0 && ref_cnt == '1));
         @(posedge clk);
         if (c_p && c_t0) ref_cnt = ref_cnt + 1'b1;
         #1 chk("R9 chain count", int'(c_q), int'(ref_cnt));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule